// File: doc/BRIEF.md
# Priority-Masked Interrupt Controller

This block collects eight device request lines and decides which one, if any, interrupts the processor. Each source has a fixed urgency equal to its index, with source 7 the most urgent. A source may interrupt only when four things hold: its request has been latched as pending, its bit in a software-written block mask is clear, its index is at or above the current level, and the global enable is on. When several sources qualify, the most urgent one wins.

On acceptance the controller performs the entry sequence in a single edge. It stores the interrupted program counter, turns the global enable off and switches to supervisor mode. It also keeps the previous mode so that a later return can restore it. A handler blocks itself, and every less urgent source, by writing a new level. That write pushes the old level onto a four-entry stack. The handler can then re-enable interrupts globally, and only sources of strictly higher urgency can preempt it. On exit the handler clears its pending bit, disables interrupts, pops the level and signals a return. The return restores the saved mode and turns the global enable back on, and the saved program counter stays on `ret_pc` for the core to jump to.

Requests are asynchronous to the instruction stream. The controller only raises `take_o` to the core, and the core finishes the instructions already in flight. Software saves and restores the saved PC and saved mode around nested handlers through the register interface.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the following are all zero: the pending set, the block mask, the level, the stack depth, the global enable, the mode, the saved mode, the saved PC and the overflow flag.
- R2: Pending bit i is set on the edge after `irq_in[i]` is high. It is cleared only by writing 1 to bit i at address 3, and a high request line wins over a clear in the same cycle. Address 3 reads the pending set.
- R3: `take_o` is high in a cycle when some source i is pending, has its mask bit at 0, satisfies i >= level, the global enable is 1 and `rte_i` is low. In that cycle `take_id` is the highest such i.
- R4: On the edge after `take_o`, `ret_pc` holds the `cur_pc` value of the take cycle, the global enable is 0, `sup_mode_o` is 1 and the saved mode holds the previous mode. Address 5 reads and writes the saved PC, and a write there is ignored in a take cycle.
- R5: Address 0 is the block mask. When bit i is 1, source i never causes `take_o`, but it still becomes pending.
- R6: A write to address 1 loads the level from `reg_wdata[3:0]` and pushes the old level onto the stack. Address 1 reads the level.
- R7: A write of any value to address 2 pops the most recently pushed level into the level register. Popping an empty stack sets the level to 0. Address 2 reads the stack depth.
- R8: A push while the stack holds 4 entries drops the saved value but still loads the new level. It also sets `overflow_o`, which stays set until reset.
- R9: Address 4 holds the control word, with bit 0 the global enable (rw), bit 1 the mode (ro), bit 2 the overflow flag (ro) and bit 3 the saved mode (rw). A control write is ignored in a take cycle or a return cycle.
- R10: On the edge after `rte_i` is high, the mode takes the saved mode and the global enable becomes 1. No take happens in a return cycle.
- R11: Accepting a source does not clear its pending bit.
- R12: While a handler runs at a raised level with the global enable on, a source below that level stays blocked, and a more urgent source is taken at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Device request lines, index = urgency |
| cur_pc | input | 16 | Program counter of the interrupted stream |
| rte_i | input | 1 | Return-from-exception strobe from the core |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| take_o | output | 1 | Interrupt accepted this cycle |
| take_id | output | 3 | Index of the accepted source |
| ret_pc | output | 16 | Saved program counter |
| sup_mode_o | output | 1 | 1 = supervisor mode, 0 = user mode |
| overflow_o | output | 1 | Sticky level-stack overflow flag |

## Verification
On every cycle the assertions check that a take happens only with the global enable on and outside a return. They also check that the taken source is pending, unmasked and at or above the level, and that the entry state follows a take. Further per-cycle checks cover the return re-enabling interrupts, pending bits falling only on a clear write, the stack depth staying within four, and the overflow flag holding. The choice of the most urgent source, preemption of a handler by a more urgent source, and the mask and level blocking lower ones are shown by the bench's scenarios and its per-cycle model. The same applies to the contents of the stack across push and pop, empty pops, and the saved-mode restoration across nested returns.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [2:0] {
    RA_MASK  = 3'd0,
    RA_LEVEL = 3'd1,
    RA_POP   = 3'd2,
    RA_PEND  = 3'd3,
    RA_CTRL  = 3'd4,
    RA_EPC   = 3'd5
  } reg_addr_e;

  localparam int CTRL_GIE   = 0;
  localparam int CTRL_MODE  = 1;
  localparam int CTRL_OVF   = 2;
  localparam int CTRL_PMODE = 3;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] pend_q
);
  // A high request line dominates a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | irq_in;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 4,
  parameter int ID_W    = 3
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] mask,
  input  logic [LVL_W-1:0]   level,
  input  logic               gie,
  input  logic               hold,
  output logic [NUM_SRC-1:0] elig_o,
  output logic               take_o,
  output logic [ID_W-1:0]    take_id
);
  function automatic logic [NUM_SRC-1:0] f_elig(
    input logic [NUM_SRC-1:0] p,
    input logic [NUM_SRC-1:0] m,
    input logic [LVL_W-1:0]   lv,
    input logic               en
  );
    logic [NUM_SRC-1:0] r;
    for (int i = 0; i < NUM_SRC; i++)
      r[i] = en && p[i] && !m[i] && (LVL_W'(i) >= lv);
    return r;
  endfunction

  // Highest set index wins.
  function automatic logic [ID_W-1:0] f_pick(input logic [NUM_SRC-1:0] v);
    logic [ID_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (v[i]) r = ID_W'(i);
    return r;
  endfunction

  assign elig_o  = f_elig(pend, mask, level, gie && !hold);
  assign take_o  = |elig_o;
  assign take_id = f_pick(elig_o);
endmodule

// File: rtl/lvl_stack.sv
module lvl_stack #(
  parameter int LVL_W     = 4,
  parameter int STK_DEPTH = 4,
  parameter int DEP_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] new_lvl,
  output logic [LVL_W-1:0] level_q,
  output logic [DEP_W-1:0] depth_q,
  output logic             ovf_q
);
  localparam int PTR_W = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;

  logic [LVL_W-1:0] stk [STK_DEPTH];
  logic             full, empty;
  logic [PTR_W-1:0] wr_idx, rd_idx;

  assign full   = (depth_q == DEP_W'(STK_DEPTH));
  assign empty  = (depth_q == '0);
  assign wr_idx = PTR_W'(depth_q);
  assign rd_idx = PTR_W'(depth_q - DEP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      depth_q <= '0;
      ovf_q   <= 1'b0;
      for (int i = 0; i < STK_DEPTH; i++) stk[i] <= '0;
    end else if (push) begin
      if (full) begin
        ovf_q <= 1'b1;
      end else begin
        stk[wr_idx] <= level_q;
        depth_q     <= depth_q + DEP_W'(1);
      end
      level_q <= new_lvl;
    end else if (pop) begin
      if (empty) begin
        level_q <= '0;
      end else begin
        level_q <= stk[rd_idx];
        depth_q <= depth_q - DEP_W'(1);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int PC_W      = 16,
  parameter int DATA_W    = 16,
  parameter int STK_DEPTH = 4,
  localparam int ID_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [PC_W-1:0]    cur_pc,
  input  logic               rte_i,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               take_o,
  output logic [ID_W-1:0]    take_id,
  output logic [PC_W-1:0]    ret_pc,
  output logic               sup_mode_o,
  output logic               overflow_o
);
  localparam int LVL_W = $clog2(NUM_SRC + 1);
  localparam int DEP_W = $clog2(STK_DEPTH + 1);

  // Named internal events, used by the bound checker.
  logic               wr_mask, wr_level, wr_pop, clr_hit, wr_ctrl, wr_epc;
  logic [NUM_SRC-1:0] clr_vec, pend_q, elig;
  logic [NUM_SRC-1:0] mask_q;
  logic [LVL_W-1:0]   level_q;
  logic [DEP_W-1:0]   depth_q;
  logic               gie_q, mode_q, pmode_q, ovf_q;
  logic [PC_W-1:0]    epc_q;

  assign wr_mask  = reg_wr && (reg_addr == RA_MASK);
  assign wr_level = reg_wr && (reg_addr == RA_LEVEL);
  assign wr_pop   = reg_wr && (reg_addr == RA_POP);
  assign clr_hit  = reg_wr && (reg_addr == RA_PEND);
  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_epc   = reg_wr && (reg_addr == RA_EPC);
  assign clr_vec  = clr_hit ? reg_wdata[NUM_SRC-1:0] : '0;

  irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .clr_vec (clr_vec),
    .pend_q  (pend_q)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_arb (
    .pend    (pend_q),
    .mask    (mask_q),
    .level   (level_q),
    .gie     (gie_q),
    .hold    (rte_i),
    .elig_o  (elig),
    .take_o  (take_o),
    .take_id (take_id)
  );

  lvl_stack #(.LVL_W(LVL_W), .STK_DEPTH(STK_DEPTH), .DEP_W(DEP_W)) u_stk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (wr_level),
    .pop     (wr_pop),
    .new_lvl (reg_wdata[LVL_W-1:0]),
    .level_q (level_q),
    .depth_q (depth_q),
    .ovf_q   (ovf_q)
  );

  // Entry sequence has priority over return and software writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      gie_q   <= 1'b0;
      mode_q  <= 1'b0;
      pmode_q <= 1'b0;
      epc_q   <= '0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata[NUM_SRC-1:0];
      if (take_o) begin
        gie_q   <= 1'b0;
        mode_q  <= 1'b1;
        pmode_q <= mode_q;
        epc_q   <= cur_pc;
      end else begin
        if (rte_i) begin
          gie_q  <= 1'b1;
          mode_q <= pmode_q;
        end else if (wr_ctrl) begin
          gie_q   <= reg_wdata[CTRL_GIE];
          pmode_q <= reg_wdata[CTRL_PMODE];
        end
        if (wr_epc) epc_q <= reg_wdata[PC_W-1:0];
      end
    end
  end

  logic [3:0] ctrl_word;
  assign ctrl_word = {pmode_q, ovf_q, mode_q, gie_q};

  always_comb begin
    case (reg_addr)
      RA_MASK:  reg_rdata = DATA_W'(mask_q);
      RA_LEVEL: reg_rdata = DATA_W'(level_q);
      RA_POP:   reg_rdata = DATA_W'(depth_q);
      RA_PEND:  reg_rdata = DATA_W'(pend_q);
      RA_CTRL:  reg_rdata = DATA_W'(ctrl_word);
      RA_EPC:   reg_rdata = DATA_W'(epc_q);
      default:  reg_rdata = '0;
    endcase
  end

  assign ret_pc     = epc_q;
  assign sup_mode_o = mode_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NUM_SRC   = 8,
  parameter int LVL_W     = 4,
  parameter int DEP_W     = 3,
  parameter int STK_DEPTH = 4,
  parameter int PC_W      = 16,
  parameter int ID_W      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               take_o,
  input logic [ID_W-1:0]    take_id,
  input logic [PC_W-1:0]    cur_pc,
  input logic [PC_W-1:0]    ret_pc,
  input logic               sup_mode_o,
  input logic               overflow_o,
  input logic               rte_i,
  input logic               gie_q,
  input logic [LVL_W-1:0]   level_q,
  input logic [DEP_W-1:0]   depth_q,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               clr_hit
);
  p_take_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (gie_q && !rte_i));

  p_take_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (pend_q[take_id] && (LVL_W'(take_id) >= level_q)));

  p_masked_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !mask_q[take_id]);

  p_entry_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (!gie_q && sup_mode_o && (ret_pc == $past(cur_pc))));

  p_return_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rte_i |=> gie_q);

  p_pend_only_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_hit |=> (($past(pend_q) & ~pend_q) == '0));

  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEP_W'(STK_DEPTH));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
endmodule

bind prio_irq_ctrl prio_irq_chk #(
  .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DEP_W(DEP_W),
  .STK_DEPTH(STK_DEPTH), .PC_W(PC_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .take_o(take_o), .take_id(take_id),
  .cur_pc(cur_pc), .ret_pc(ret_pc), .sup_mode_o(sup_mode_o),
  .overflow_o(overflow_o), .rte_i(rte_i), .gie_q(gie_q),
  .level_q(level_q), .depth_q(depth_q), .pend_q(pend_q),
  .mask_q(mask_q), .clr_hit(clr_hit)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_in = '0;
  logic [15:0] cur_pc = '0;
  logic        rte_i = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        take_o;
  logic [2:0]  take_id;
  logic [15:0] ret_pc;
  logic        sup_mode_o;
  logic        overflow_o;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cur_pc(cur_pc),
    .rte_i(rte_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .take_o(take_o),
    .take_id(take_id), .ret_pc(ret_pc), .sup_mode_o(sup_mode_o),
    .overflow_o(overflow_o)
  );

  always #4 clk = ~clk;   // 125 MHz

  int checks = 0, fails = 0, cycle_n = 0;
  bit done = 0;

  // Next-cycle stimulus, applied at the falling edge.
  int n_irq = 0, n_wr = 0, n_addr = 0, n_wdata = 0, n_rte = 0;

  // Reference state.
  int m_pend, m_mask, m_lvl, m_gie, m_mode, m_pmode, m_epc, m_ovf;
  int m_stk[$];

  // Values seen in the last cycle.
  int s_take, s_id, s_rdata, s_ret, s_sup, s_ovf, s_pc;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycle_n);
    end
  endtask

  task automatic model_reset();
    m_pend = 0; m_mask = 0; m_lvl = 0; m_gie = 0; m_mode = 0;
    m_pmode = 0; m_epc = 0; m_ovf = 0; m_stk.delete();
  endtask

  function automatic int exp_winner(output int id);
    int hit = 0;
    id = 0;
    if (m_gie == 1 && n_rte == 0)
      for (int i = 7; i >= 0; i--)
        if (hit == 0 && m_pend[i] && !m_mask[i] && i >= m_lvl) begin
          hit = 1; id = i;
        end
    return hit;
  endfunction

  function automatic int exp_rdata();
    case (n_addr)
      0: return m_mask;
      1: return m_lvl;
      2: return m_stk.size();
      3: return m_pend;
      4: return (m_pmode << 3) | (m_ovf << 2) | (m_mode << 1) | m_gie;
      5: return m_epc;
      default: return 0;
    endcase
  endfunction

  task automatic cyc();
    int e_take, e_id, e_rd;
    string rtag;
    @(negedge clk);
    cycle_n++;
    irq_in = n_irq[7:0]; rte_i = n_rte[0]; reg_wr = n_wr[0];
    reg_addr = n_addr[2:0]; reg_wdata = n_wdata[15:0];
    cur_pc = 16'h1000 + cycle_n[15:0];
    #1;
    e_take = exp_winner(e_id);
    e_rd = exp_rdata();
    chk("R3 take_o", int'(take_o), e_take);
    if (e_take == 1) chk("R3 take_id", int'(take_id), e_id);
    chk("R4 ret_pc", int'(ret_pc), m_epc);
    chk("R4 R10 sup_mode_o", int'(sup_mode_o), m_mode);
    chk("R8 overflow_o", int'(overflow_o), m_ovf);
    case (n_addr)
      0: rtag = "R5 rdata mask";
      1: rtag = "R6 rdata level";
      2: rtag = "R7 rdata depth";
      3: rtag = "R2 rdata pend";
      4: rtag = "R9 rdata ctrl";
      default: rtag = "R4 rdata epc";
    endcase
    chk(rtag, int'(reg_rdata), e_rd);
    s_take = int'(take_o); s_id = int'(take_id); s_rdata = int'(reg_rdata);
    s_ret = int'(ret_pc); s_sup = int'(sup_mode_o); s_ovf = int'(overflow_o);
    s_pc = int'(cur_pc);
    @(posedge clk);
    // Reference update from the pre-edge state.
    begin
      int clr;
      clr = (n_wr == 1 && n_addr == 3) ? (n_wdata & 'hFF) : 0;
      if (n_wr == 1 && n_addr == 0) m_mask = n_wdata & 'hFF;
      if (n_wr == 1 && n_addr == 1) begin
        if (m_stk.size() < 4) m_stk.push_back(m_lvl); else m_ovf = 1;
        m_lvl = n_wdata & 'hF;
      end
      if (n_wr == 1 && n_addr == 2) begin
        if (m_stk.size() > 0) m_lvl = m_stk.pop_back(); else m_lvl = 0;
      end
      if (e_take == 1) begin
        m_pmode = m_mode; m_gie = 0; m_mode = 1; m_epc = s_pc;
      end else begin
        if (n_rte == 1) begin
          m_gie = 1; m_mode = m_pmode;
        end else if (n_wr == 1 && n_addr == 4) begin
          m_gie = n_wdata & 1; m_pmode = (n_wdata >> 3) & 1;
        end
        if (n_wr == 1 && n_addr == 5) m_epc = n_wdata & 'hFFFF;
      end
      m_pend = ((m_pend & ~clr) | n_irq) & 'hFF;
    end
    n_irq = 0; n_wr = 0; n_addr = 0; n_wdata = 0; n_rte = 0;
  endtask

  task automatic wr(int a, int d);
    n_wr = 1; n_addr = a; n_wdata = d; cyc();
  endtask

  task automatic rd(int a);
    n_addr = a; cyc();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int pc1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(4); chk("R1 ctrl after reset", s_rdata, 0);
    rd(3); chk("R1 pend after reset", s_rdata, 0);
    rd(2); chk("R1 depth after reset", s_rdata, 0);

    wr(0, 'h01);            // block source 0
    wr(4, 'h1);             // global enable
    n_irq = 'h01; cyc();
    rd(3); chk("R5 masked source not taken", s_take, 0);
    chk("R2 masked source still pending", s_rdata, 'h01);

    n_irq = 'h04; cyc();
    rd(3); chk("R3 take of source 2", s_take, 1); chk("R3 take_id 2", s_id, 2);
    pc1 = s_pc;
    rd(4); chk("R4 entry ctrl word", s_rdata, 'h2);
    chk("R4 saved pc", s_ret, pc1);

    wr(1, 3);               // raise level above sources 0..2
    wr(4, 'h1);
    n_irq = 'h02; cyc();
    rd(3); chk("R12 lower source blocked", s_take, 0);
    n_irq = 'h80; cyc();
    rd(3); chk("R12 preempt by source 7", s_take, 1); chk("R12 take_id 7", s_id, 7);
    rd(3); chk("R11 pending kept after take", s_rdata & 'h80, 'h80);

    wr(1, 8); wr(3, 'h80); wr(4, 'h8); wr(2, 0);
    n_rte = 1; cyc();
    rd(4); chk("R10 nested return keeps supervisor", s_sup, 1);
    wr(5, pc1); wr(4, 'h1);
    wr(3, 'h04); wr(4, 'h0); wr(2, 0);
    n_rte = 1; cyc();
    chk("R10 no take in return cycle", s_take, 0);
    rd(1);
    chk("R10 user mode after return", s_sup, 0);
    chk("R10 pc restored", s_ret, pc1);
    chk("R3 source 1 taken at level 0", s_id, 1);
    wr(3, 'h03); wr(4, 'h0); n_rte = 1; cyc();

    for (int k = 1; k <= 5; k++) wr(1, k);
    rd(2); chk("R8 overflow flag", s_ovf, 1); chk("R8 depth capped", s_rdata, 4);
    wr(2, 0); rd(1); chk("R7 pop restores", s_rdata, 3);
    for (int k = 0; k < 4; k++) wr(2, 0);
    rd(1); chk("R7 empty pop gives 0", s_rdata, 0);
    wr(0, 0);

    for (int k = 0; k < 4000; k++) begin
      n_irq = $urandom & $urandom & $urandom & $urandom & 'hFF;
      if (($urandom % 3) == 0) begin
        n_wr = 1; n_addr = $urandom % 8; n_wdata = $urandom & 'hFFFF;
        if (n_addr == 1) n_wdata = $urandom % 10;
      end else begin
        n_addr = $urandom % 8;
      end
      if (($urandom % 20) == 0) n_rte = 1;
      cyc();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule